// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits beside a two-port memory and decides what happens when both ports reach the same word at once. Each port presents an enable, an address and a write request every cycle. When both ports are enabled on the same address, the block lets one port proceed and raises an active-low busy flag on the other. It also produces a gated write enable per port, so that the memory never takes a write from a port that has lost arbitration. The decision looks only at enables and addresses. Whether an access is a read or a write does not affect the outcome.

The block is a one-stage pipeline. Requests sampled at a clock edge give busy flags and write gates in the next cycle. If one port was already sitting on a location in the previous cycle when the other port arrives, the earlier port keeps the word. If both arrive together, the left port wins. The winner keeps the grant for as long as both ports stay on that word.

A mode input turns the block into a slave for width expansion. A slave does no arbitration of its own. Its busy inputs, which carry the verdict of a single master, act only as write inhibits, and its own busy outputs stay inactive.

Top module: `dpbusy_arbiter`

## Requirements
- R1: A busy output goes low only in the cycle right after a cycle in which both ports were enabled with equal addresses. In every other cycle both busy outputs are high (1 = not busy).
- R2: The two busy outputs are never low in the same cycle.
- R3: In master mode, when both ports reach the same address in the same cycle, and neither was enabled on that address in the previous cycle, the left port proceeds. The next cycle then shows `r_busy_n`=0 and `l_busy_n`=1.
- R4: In master mode, if one port was enabled on an address in the previous cycle and the other port arrives on it now, the port that was there first proceeds. The newcomer sees busy, and this holds when the newcomer is the left port.
- R5: A grant is held while both ports stay enabled on the collided address. In the cycle after the winner changes address or drops its enable, both busy outputs are high again.
- R6: The write request inputs do not affect arbitration. A collision between two reads raises busy exactly as a collision between two writes does.
- R7: `x_wr_gate` is 1 exactly in the cycle after port x was enabled with its write request at 1 and was not blocked. In master mode a port is blocked when it loses arbitration, so a write from the busy side is never passed on.
- R8: In slave mode (`master_mode`=0) both busy outputs stay high. A port's writes are blocked exactly when its busy input was 0 in the request cycle, and address collisions block nothing.
- R9: While reset is active, and in the first cycle after it, both busy outputs are 1 and both write gates are 0.
- R10: Changing `master_mode` takes effect on the request cycle in which it is sampled, with the usual one-cycle latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = slave, where busy inputs inhibit writes |
| l_en | input | 1 | Left port enable |
| l_addr | input | ADDR_W | Left port address |
| l_wr | input | 1 | Left port write request |
| l_busy_n_in | input | 1 | Left write inhibit from the master (slave mode), active low |
| r_en | input | 1 | Right port enable |
| r_addr | input | ADDR_W | Right port address |
| r_wr | input | 1 | Right port write request |
| r_busy_n_in | input | 1 | Right write inhibit from the master (slave mode), active low |
| l_busy_n | output | 1 | Left busy, active low |
| r_busy_n | output | 1 | Right busy, active low |
| l_wr_gate | output | 1 | Gated write enable to the memory for the left port |
| r_wr_gate | output | 1 | Gated write enable to the memory for the right port |

## Verification
The arbiter is driven with disjoint addresses, which must never raise busy. It is then driven with simultaneous same-address arrivals, which must favour the left port, and with staggered arrivals from each side, which show that first arrival beats the fixed left priority. Read-read collisions against write-write collisions show that the write requests play no part in arbitration. Holding and then moving the winner or the loser separates grant retention from release. Slave runs with colliding addresses and toggled busy inputs show that only the inhibit inputs gate writes in that mode.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
endpackage

// File: rtl/dpb_match.sv
module dpb_match #(
   parameter int ADDR_W = 11
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [dpb_pkg::NUM_PORTS-1:0]          en,
   input  logic [dpb_pkg::NUM_PORTS-1:0][ADDR_W-1:0] addr,
   output logic                                   collide,
   output logic [dpb_pkg::NUM_PORTS-1:0]          stay
);
   localparam int NP = dpb_pkg::NUM_PORTS;

   assign collide = en[0] && en[1] && (addr[0] == addr[1]);

   for (genvar p = 0; p < NP; p++) begin : g_port
      logic              prev_en_q;
      logic [ADDR_W-1:0] prev_addr_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prev_en_q   <= 1'b0;
            prev_addr_q <= '0;
         end else begin
            prev_en_q   <= en[p];
            prev_addr_q <= addr[p];
         end
      end

      assign stay[p] = en[p] && prev_en_q && (prev_addr_q == addr[p]);
   end
endmodule

// File: rtl/dpb_grant.sv
module dpb_grant (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          collide,
   input  logic [dpb_pkg::NUM_PORTS-1:0] stay,
   output dpb_pkg::owner_e               owner_d
);
   import dpb_pkg::*;

   owner_e owner_q;

   always_comb begin
      if (!collide)
         owner_d = OWN_NONE;
      else if (owner_q != OWN_NONE && stay[0] && stay[1])
         owner_d = owner_q;
      else if (stay[1] && !stay[0])
         owner_d = OWN_RIGHT;
      else
         owner_d = OWN_LEFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) owner_q <= OWN_NONE;
      else        owner_q <= owner_d;
   end

   AST_HOLD_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q != OWN_NONE && collide && stay[0] && stay[1]) |-> (owner_d == owner_q)); // R5
   AST_NO_COLLIDE_NO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      !collide |-> (owner_d == OWN_NONE)); // R1
endmodule

// File: rtl/dpb_gate.sv
module dpb_gate (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          master_mode,
   input  dpb_pkg::owner_e               owner_d,
   input  logic [dpb_pkg::NUM_PORTS-1:0] en,
   input  logic [dpb_pkg::NUM_PORTS-1:0] wr,
   input  logic [dpb_pkg::NUM_PORTS-1:0] busy_n_in,
   output logic [dpb_pkg::NUM_PORTS-1:0] busy_n,
   output logic [dpb_pkg::NUM_PORTS-1:0] wr_gate
);
   import dpb_pkg::*;
   localparam int NP = NUM_PORTS;

   for (genvar p = 0; p < NP; p++) begin : g_port
      localparam owner_e LOSE_TO = (p == 0) ? OWN_RIGHT : OWN_LEFT;
      logic lost, blocked;

      assign lost    = master_mode && (owner_d == LOSE_TO);
      assign blocked = master_mode ? lost : !busy_n_in[p];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_n[p]  <= 1'b1;
            wr_gate[p] <= 1'b0;
         end else begin
            busy_n[p]  <= !lost;
            wr_gate[p] <= en[p] && wr[p] && !blocked;
         end
      end

      AST_GATE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         wr_gate[p] |-> $past(en[p] && wr[p])); // R7
      AST_BUSY_SIDE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         !busy_n[p] |-> !wr_gate[p]); // R7
   end

   AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!busy_n[0] && !busy_n[1])); // R2
endmodule

// File: rtl/dpbusy_arbiter.sv
module dpbusy_arbiter #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_wr,
   input  logic              l_busy_n_in,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_wr,
   input  logic              r_busy_n_in,
   output logic              l_busy_n,
   output logic              r_busy_n,
   output logic              l_wr_gate,
   output logic              r_wr_gate
);
   import dpb_pkg::*;
   localparam int NP = NUM_PORTS;

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
      $error("dpbusy_arbiter: ADDR_W must lie in 1..32");
   end

   logic [NP-1:0][ADDR_W-1:0] addr_v;
   logic [NP-1:0]             en_v, wr_v, bin_v, busy_v, gate_v, stay_v;
   logic                      collide;
   owner_e                    owner_d;

   assign addr_v = {r_addr, l_addr};
   assign en_v   = {r_en, l_en};
   assign wr_v   = {r_wr, l_wr};
   assign bin_v  = {r_busy_n_in, l_busy_n_in};

   dpb_match #(.ADDR_W(ADDR_W)) match_i (
      .clk(clk), .rst_n(rst_n), .en(en_v), .addr(addr_v),
      .collide(collide), .stay(stay_v)
   );

   dpb_grant grant_i (
      .clk(clk), .rst_n(rst_n), .collide(collide), .stay(stay_v),
      .owner_d(owner_d)
   );

   dpb_gate gate_i (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .owner_d(owner_d),
      .en(en_v), .wr(wr_v), .busy_n_in(bin_v),
      .busy_n(busy_v), .wr_gate(gate_v)
   );

   assign l_busy_n  = busy_v[0];
   assign r_busy_n  = busy_v[1];
   assign l_wr_gate = gate_v[0];
   assign r_wr_gate = gate_v[1];

   AST_BUSY_ONLY_ON_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_busy_n || !r_busy_n) |-> $past(l_en && r_en && (l_addr == r_addr))); // R1
   AST_SIMULTANEOUS_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && collide && !stay_v[0] && !stay_v[1]) |=> (!r_busy_n && l_busy_n)); // R3
   AST_SLAVE_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> (l_busy_n && r_busy_n)); // R8
   AST_SLAVE_INHIBIT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && !l_busy_n_in) |=> !l_wr_gate); // R8
   AST_SLAVE_INHIBIT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_mode && !r_busy_n_in) |=> !r_wr_gate); // R8
endmodule

// File: tb/dpbusy_arbiter_tb.sv
module dpbusy_arbiter_tb_top;
   localparam int AW = 11;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          master_mode = 1'b1;
   logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_busy_n_in = 1'b1, r_busy_n_in = 1'b1;
   logic          l_busy_n, r_busy_n, l_wr_gate, r_wr_gate;

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R9";
   bit    done = 1'b0;

   // behavioural reference state
   int    m_owner = 0;       // 0 none, 1 left, 2 right
   bit    m_ple = 0, m_pre = 0;
   int    m_pla = 0, m_pra = 0;
   bit    e_lb = 1, e_rb = 1, e_lg = 0, e_rg = 0;

   always #5 clk = ~clk;

   dpbusy_arbiter #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr), .l_busy_n_in(l_busy_n_in),
      .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr), .r_busy_n_in(r_busy_n_in),
      .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
      .l_wr_gate(l_wr_gate), .r_wr_gate(r_wr_gate)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_owner = 0; m_ple = 0; m_pre = 0; m_pla = 0; m_pra = 0;
         e_lb = 1; e_rb = 1; e_lg = 0; e_rg = 0;
      end else begin
         bit coll, ls, rs, blk_l, blk_r;
         int nd;
         coll = l_en && r_en && (l_addr == r_addr);
         ls   = l_en && m_ple && (int'(l_addr) == m_pla);
         rs   = r_en && m_pre && (int'(r_addr) == m_pra);
         if (!coll) nd = 0;
         else if (m_owner != 0 && ls && rs) nd = m_owner;
         else if (rs && !ls) nd = 2;
         else nd = 1;
         if (master_mode) begin
            blk_l = (nd == 2); blk_r = (nd == 1);
         end else begin
            blk_l = !l_busy_n_in; blk_r = !r_busy_n_in;
         end
         e_lb = !(master_mode && nd == 2);
         e_rb = !(master_mode && nd == 1);
         e_lg = l_en && l_wr && !blk_l;
         e_rg = r_en && r_wr && !blk_r;
         m_owner = nd;
         m_ple = l_en; m_pre = r_en; m_pla = int'(l_addr); m_pra = int'(r_addr);
      end
   end

   task automatic chk(string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done && rst_n) begin
         chk("l_busy_n", l_busy_n, e_lb);
         chk("r_busy_n", r_busy_n, e_rb);
         chk("l_wr_gate", l_wr_gate, e_lg);
         chk("r_wr_gate", r_wr_gate, e_rg);
      end
   end

   task automatic drive(bit le, int la, bit lw, bit re, int ra, bit rw, int n = 1);
      @(negedge clk);
      l_en = le; l_addr = AW'(la); l_wr = lw;
      r_en = re; r_addr = AW'(ra); r_wr = rw;
      repeat (n - 1) @(negedge clk);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R9";
      chk("reset l_busy_n", l_busy_n, 1'b1);
      chk("reset r_busy_n", r_busy_n, 1'b1);
      chk("reset l_wr_gate", l_wr_gate, 1'b0);
      chk("reset r_wr_gate", r_wr_gate, 1'b0);
      rst_n = 1'b1;
      // disjoint addresses: no busy, both writes pass
      cur_req = "R1";
      drive(1, 16, 1, 1, 17, 1, 3);
      // simultaneous write collision: left wins (drop enables first)
      drive(0, 0, 0, 0, 0, 0, 2);
      cur_req = "R3";
      drive(1, 100, 1, 1, 100, 1);
      // hold several cycles
      cur_req = "R5";
      drive(1, 100, 1, 1, 100, 1, 4);
      // winner leaves: release
      drive(1, 101, 1, 1, 100, 1, 2);
      // staggered: right first, then left arrives
      drive(0, 0, 0, 0, 0, 0, 2);
      cur_req = "R4";
      drive(0, 0, 0, 1, 200, 1);
      drive(1, 200, 1, 1, 200, 1, 3);
      // winner (right) drops enable
      cur_req = "R5";
      drive(1, 200, 1, 0, 200, 1, 2);
      // staggered from the left side
      cur_req = "R4";
      drive(1, 300, 1, 1, 301, 1);
      drive(1, 300, 1, 1, 300, 1, 2);
      // loser moves away, then back: new arrival loses to stayer
      drive(1, 300, 1, 1, 302, 1);
      drive(1, 300, 1, 1, 300, 1, 2);
      // read-read collision
      drive(0, 0, 0, 0, 0, 0, 2);
      cur_req = "R6";
      drive(1, 5, 0, 1, 5, 0, 3);
      drive(1, 5, 1, 1, 5, 0, 2);
      drive(1, 5, 0, 1, 5, 1, 2);
      // both jump together to a new shared address
      cur_req = "R3";
      drive(1, 9, 1, 1, 9, 1, 2);
      cur_req = "R2";
      drive(1, 2047, 1, 1, 2047, 1, 2);
      // slave mode
      drive(0, 0, 0, 0, 0, 0, 2);
      cur_req = "R10";
      master_mode = 1'b0;
      cur_req = "R8";
      drive(1, 50, 1, 1, 50, 1, 3);
      l_busy_n_in = 1'b0;
      drive(1, 50, 1, 1, 50, 1, 2);
      l_busy_n_in = 1'b1; r_busy_n_in = 1'b0;
      drive(1, 60, 1, 1, 61, 1, 2);
      l_busy_n_in = 1'b0;
      drive(1, 70, 1, 1, 70, 0, 2);
      l_busy_n_in = 1'b1; r_busy_n_in = 1'b1;
      // back to master mid-collision
      cur_req = "R10";
      master_mode = 1'b1;
      drive(1, 80, 1, 1, 80, 1, 3);
      // inhibit inputs ignored in master mode
      cur_req = "R7";
      l_busy_n_in = 1'b0; r_busy_n_in = 1'b0;
      drive(1, 81, 1, 1, 82, 1, 2);
      l_busy_n_in = 1'b1; r_busy_n_in = 1'b1;
      drive(0, 0, 1, 1, 90, 1, 2);
      drive(0, 0, 0, 0, 0, 0, 2);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule